// File: doc/BRIEF.md
# Source-Routed Wormhole Network Switch

This block is a five-way crossbar switch for an on-chip packet network. Each input link delivers flits that carry a 32-bit payload and a 2-bit kind tag. Every input has a shallow FIFO. Each output has its own allocator, which picks one waiting packet at a time. The route is carried inside the packet. The low field of the head flit names the output for this hop. The switch shifts that field away so that the next switch finds its own port number in the same low bits.

Switching is wormhole. Once a head flit wins an output, that output serves only the same input until the packet's closing flit has left. Each instance selects its allocation policy: a rotating-priority scheme, or a fixed scheme in which the lowest-numbered input wins. Back-pressure is a simple stop/go level in each direction. The switch raises its stop signal toward a sender while one free FIFO slot still remains, so one flit already in flight on a registered link is absorbed. A stop from downstream keeps the switch from presenting further flits on that output.

Top module: `nocsw_switch`

## Requirements
- R1: A flit's kind tag is encoded as body=0, head=1, tail=2, single (head and tail at once)=3. Every flit presented with `in_valid` high is stored in that input's 4-entry FIFO. Flits from one input leave in the order they arrived.
- R2: After reset all outputs are invalid and all `in_stall` lines are low. `in_stall[i]` is high exactly when input i's FIFO holds DEPTH-1 (3) or more flits.
- R3: A head or single flit leaves on the output whose number equals its data bits [2:0]. Its forwarded data is the received data shifted right by 3 with zeros filled in at the top. Body and tail data pass unchanged.
- R4: After a head flit is granted an output, that output carries only flits of the same input until the tail flit has left. No other packet is interleaved.
- R5: In rotating mode (RR_EN=1), the first requester found from the output's priority pointer upward, wrapping around, is granted. The pointer moves to the granted input plus one only when a tail or single flit leaves. It starts at input 0.
- R6: In fixed mode (RR_EN=0), the lowest-numbered requesting input is always granted.
- R7: If `out_stall[o]` is high in a cycle, output o presents no flit in the following cycle. The waiting flits stay queued.
- R8: A flit written into an empty FIFO at one clock edge is transferred at the next edge and is visible at the output port after it, when the output is free and not stalled.
- R9: Distinct outputs serve distinct inputs in the same cycle, independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NP | Flit present on each input link |
| in_kind | input | 2*NP | Kind tag per input, 2 bits each |
| in_data | input | DW*NP | Payload per input |
| in_stall | output | NP | Stop request to each upstream sender |
| out_valid | output | NP | Flit present on each output link |
| out_kind | output | 2*NP | Kind tag per output |
| out_data | output | DW*NP | Payload per output (head route shifted) |
| out_stall | input | NP | Stop request from each downstream receiver |

## Verification
Three corner cases get the most attention. The first is contention among several inputs for one output while packets are in progress. A design that re-arbitrated on body flits would interleave packets, and a design that moved the rotating pointer on every flit would grant in the wrong order. The second is FIFO fill under a sender that reacts to stop one cycle late. A stop threshold that is off by one would either overflow and lose a flit or block a sender too early. The third is downstream stop on busy outputs: a design that ignored it would keep presenting flits. The head-flit shift is also checked, because a wrong shift amount sends the packet to the wrong port at the next hop. Both arbitration variants run side by side against behavioural queue models under mixed packet lengths and stop patterns.

// File: rtl/nocsw_pkg.sv
package nocsw_pkg;
  typedef enum logic [1:0] {
    FT_BODY = 2'd0,
    FT_HEAD = 2'd1,
    FT_TAIL = 2'd2,
    FT_SOLO = 2'd3
  } flit_kind_e;

  function automatic logic opens_pkt(input logic [1:0] k);
    return (k == FT_HEAD) || (k == FT_SOLO);
  endfunction

  function automatic logic ends_pkt(input logic [1:0] k);
    return (k == FT_TAIL) || (k == FT_SOLO);
  endfunction
endpackage

// File: rtl/nocsw_fifo.sv
module nocsw_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push) wr_d = (wr_q == PTRW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTRW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/nocsw_arb.sv
module nocsw_arb #(
  parameter int NP    = 5,
  parameter bit RR_EN = 1'b1,
  localparam int IW   = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic          adv,
  input  logic [IW-1:0] adv_idx,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] start;

  generate
    if (RR_EN) begin : g_rr
      logic [IW-1:0] ptr_q, ptr_d;
      always_comb begin
        ptr_d = ptr_q;
        if (adv) ptr_d = (adv_idx == IW'(NP - 1)) ? '0 : adv_idx + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
      end
      assign start = ptr_q;
    end else begin : g_fixed
      assign start = '0;
    end
  endgenerate

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < NP; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= NP) j = j - NP;
      if (!any && req[j]) begin
        any = 1'b1;
        idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/nocsw_outport.sv
module nocsw_outport
  import nocsw_pkg::*;
#(
  parameter int NP    = 5,
  parameter int DW    = 32,
  parameter int PW    = 3,
  parameter bit RR_EN = 1'b1,
  localparam int IW   = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stall,
  input  logic [NP-1:0]  req,
  input  logic [NP-1:0]  nonempty,
  input  logic [2*NP-1:0]  hd_kind,
  input  logic [DW*NP-1:0] hd_data,
  output logic [NP-1:0]  pop,
  output logic           o_valid,
  output logic [1:0]     o_kind,
  output logic [DW-1:0]  o_data
);
  logic          locked_q, locked_d;
  logic [IW-1:0] owner_q, owner_d;
  logic          arb_any;
  logic [IW-1:0] arb_idx, sel;
  logic [1:0]    kind;
  logic [DW-1:0] data, data_fwd;
  logic          go;

  nocsw_arb #(.NP(NP), .RR_EN(RR_EN)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (locked_q ? '0 : req),
    .adv     (go && ends_pkt(kind)),
    .adv_idx (sel),
    .any     (arb_any),
    .idx     (arb_idx)
  );

  always_comb begin
    sel      = locked_q ? owner_q : arb_idx;
    kind     = hd_kind[2*sel +: 2];
    data     = hd_data[DW*sel +: DW];
    go       = !stall && (locked_q ? nonempty[owner_q] : arb_any);
    data_fwd = opens_pkt(kind) ? (data >> PW) : data;
    pop      = '0;
    pop[sel] = go;
    locked_d = locked_q;
    owner_d  = owner_q;
    if (go) begin
      if (!locked_q && kind == FT_HEAD) begin
        locked_d = 1'b1;
        owner_d  = sel;
      end else if (locked_q && ends_pkt(kind)) begin
        locked_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      o_valid  <= 1'b0;
      o_kind   <= '0;
      o_data   <= '0;
    end else begin
      locked_q <= locked_d;
      owner_q  <= owner_d;
      o_valid  <= go;
      if (go) begin
        o_kind <= kind;
        o_data <= data_fwd;
      end
    end
  end
endmodule

// File: rtl/nocsw_switch.sv
module nocsw_switch
  import nocsw_pkg::*;
#(
  parameter int NP    = 5,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int PW    = 3,
  parameter bit RR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_valid,
  input  logic [2*NP-1:0]  in_kind,
  input  logic [DW*NP-1:0] in_data,
  output logic [NP-1:0]    in_stall,
  output logic [NP-1:0]    out_valid,
  output logic [2*NP-1:0]  out_kind,
  output logic [DW*NP-1:0] out_data,
  input  logic [NP-1:0]    out_stall
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]      cnt [NP];
  logic [DW+1:0]      head [NP];
  logic [NP-1:0]      nonempty, pop_in;
  logic [2*NP-1:0]    hk_flat;
  logic [DW*NP-1:0]   hd_flat;
  logic [NP-1:0]      reqm [NP];
  logic [NP-1:0]      popm [NP];
  logic [NP*NP-1:0]   pop_flat;
  logic [NP*CW-1:0]   cnt_flat;

  generate
    for (genvar i = 0; i < NP; i++) begin : g_in
      nocsw_fifo #(.W(DW + 2), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid[i]),
        .pop   (pop_in[i]),
        .wdata ({in_kind[2*i +: 2], in_data[DW*i +: DW]}),
        .rdata (head[i]),
        .count (cnt[i])
      );
      assign nonempty[i]           = (cnt[i] != '0);
      assign in_stall[i]           = (cnt[i] >= CW'(DEPTH - 1));
      assign hk_flat[2*i +: 2]     = head[i][DW +: 2];
      assign hd_flat[DW*i +: DW]   = head[i][DW-1:0];
      assign cnt_flat[CW*i +: CW]  = cnt[i];
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
      nocsw_outport #(.NP(NP), .DW(DW), .PW(PW), .RR_EN(RR_EN)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (out_stall[o]),
        .req      (reqm[o]),
        .nonempty (nonempty),
        .hd_kind  (hk_flat),
        .hd_data  (hd_flat),
        .pop      (popm[o]),
        .o_valid  (out_valid[o]),
        .o_kind   (out_kind[2*o +: 2]),
        .o_data   (out_data[DW*o +: DW])
      );
      assign pop_flat[NP*o +: NP] = popm[o];
    end
  endgenerate

  always_comb begin
    pop_in = '0;
    for (int o = 0; o < NP; o++) begin
      pop_in = pop_in | popm[o];
      for (int i = 0; i < NP; i++) begin
        reqm[o][i] = nonempty[i] && opens_pkt(head[i][DW +: 2]) &&
                     (head[i][PW-1:0] == PW'(o));
      end
    end
  end
endmodule

// File: rtl/nocsw_switch_chk.sv
module nocsw_switch_chk
  import nocsw_pkg::*;
#(
  parameter int NP    = 5,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int PW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP-1:0]    in_valid,
  input logic [NP-1:0]    out_valid,
  input logic [2*NP-1:0]  out_kind,
  input logic [DW*NP-1:0] out_data,
  input logic [NP-1:0]    out_stall,
  input logic [NP*NP-1:0] pop_flat,
  input logic [NP*CW-1:0] cnt_flat
);
  logic [NP-1:0] in_pkt;
  logic [NP-1:0] col [NP];

  always_comb begin
    for (int i = 0; i < NP; i++)
      for (int o = 0; o < NP; o++)
        col[i][o] = pop_flat[NP*o + i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt <= '0;
    else begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_kind[2*o +: 2] == FT_HEAD) in_pkt[o] <= 1'b1;
        else if (out_valid[o] && out_kind[2*o +: 2] == FT_TAIL) in_pkt[o] <= 1'b0;
      end
    end
  end

  generate
    for (genvar i = 0; i < NP; i++) begin : g_ia
      // R1: an accepted flit never lands in a full FIFO
      assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[i] |-> (cnt_flat[CW*i +: CW] < CW'(DEPTH)));
      // R9: one input is drained by at most one output per cycle
      assert_single_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col[i]));
    end
    for (genvar o = 0; o < NP; o++) begin : g_oa
      assert_stall_obeyed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_stall[o] |=> !out_valid[o]);
      assert_worm_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[o] && in_pkt[o]) |->
          (out_kind[2*o +: 2] == FT_BODY || out_kind[2*o +: 2] == FT_TAIL));
      assert_worm_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[o] && !in_pkt[o]) |->
          (out_kind[2*o +: 2] == FT_HEAD || out_kind[2*o +: 2] == FT_SOLO));
      assert_route_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[o] && opens_pkt(out_kind[2*o +: 2])) |->
          (out_data[DW*o + DW - 1 -: PW] == '0));
    end
  endgenerate
endmodule

bind nocsw_switch nocsw_switch_chk #(.NP(NP), .DW(DW), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_kind  (out_kind),
  .out_data  (out_data),
  .out_stall (out_stall),
  .pop_flat  (pop_flat),
  .cnt_flat  (cnt_flat)
);

// File: tb/sim_nocsw_switch.sv
module sim_ref #(
  parameter int NP = 5, parameter int DW = 32, parameter int DEPTH = 4,
  parameter int PW = 3, parameter bit RR = 1'b1
) (
  input  logic clk, input logic rst_n,
  input  logic [NP-1:0] vin, input logic [2*NP-1:0] kin,
  input  logic [DW*NP-1:0] din, input logic [NP-1:0] ostall,
  output logic [NP-1:0] ev, output logic [2*NP-1:0] ek,
  output logic [DW*NP-1:0] ed, output logic [NP-1:0] es
);
  logic [DW+1:0] q [NP][$];
  int lk [NP];
  int ptr [NP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin q[i].delete(); lk[i] = -1; ptr[i] = 0; end
      ev = '0; ek = '0; ed = '0; es = '0;
    end else begin
      bit pp [NP];
      for (int i = 0; i < NP; i++) pp[i] = 0;
      for (int o = 0; o < NP; o++) begin
        int s;
        s = -1;
        ev[o] = 1'b0;
        if (!ostall[o]) begin
          if (lk[o] >= 0) begin
            if (q[lk[o]].size() > 0) s = lk[o];
          end else begin
            for (int k = 0; k < NP; k++) begin
              int j;
              logic [1:0] hk;
              j = ((RR ? ptr[o] : 0) + k) % NP;
              if (s < 0 && q[j].size() > 0) begin
                hk = q[j][0][DW +: 2];
                if ((hk == 2'd1 || hk == 2'd3) && int'(q[j][0][PW-1:0]) == o) s = j;
              end
            end
          end
          if (s >= 0) begin
            logic [1:0] kk;
            kk = q[s][0][DW +: 2];
            pp[s] = 1;
            ev[o] = 1'b1;
            ek[2*o +: 2] = kk;
            ed[DW*o +: DW] = (kk == 2'd1 || kk == 2'd3) ? (q[s][0][DW-1:0] >> PW) : q[s][0][DW-1:0];
            if (lk[o] < 0 && kk == 2'd1) lk[o] = s;
            else if (lk[o] >= 0 && (kk == 2'd2 || kk == 2'd3)) lk[o] = -1;
            if (kk == 2'd2 || kk == 2'd3) ptr[o] = (s + 1) % NP;
          end
        end
      end
      for (int i = 0; i < NP; i++) begin
        if (pp[i]) void'(q[i].pop_front());
        if (vin[i]) q[i].push_back({kin[2*i +: 2], din[DW*i +: DW]});
        es[i] = (q[i].size() >= DEPTH - 1);
      end
    end
  end
endmodule

module sim_nocsw_switch;
  localparam int NP = 5, DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] vin = '0, ostall = '0;
  logic [2*NP-1:0] kin = '0;
  logic [DW*NP-1:0] din = '0;
  logic [NP-1:0] v0, s0, v1, s1, ev0, es0, ev1, es1;
  logic [2*NP-1:0] k0, k1, ek0, ek1;
  logic [DW*NP-1:0] d0, d1, ed0, ed1;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nocsw_switch #(.RR_EN(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(vin), .in_kind(kin),
    .in_data(din), .in_stall(s0), .out_valid(v0), .out_kind(k0), .out_data(d0), .out_stall(ostall));
  nocsw_switch #(.RR_EN(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(vin), .in_kind(kin),
    .in_data(din), .in_stall(s1), .out_valid(v1), .out_kind(k1), .out_data(d1), .out_stall(ostall));
  sim_ref #(.RR(1'b1)) m0 (.clk(clk), .rst_n(rst_n), .vin(vin), .kin(kin), .din(din),
    .ostall(ostall), .ev(ev0), .ek(ek0), .ed(ed0), .es(es0));
  sim_ref #(.RR(1'b0)) m1 (.clk(clk), .rst_n(rst_n), .vin(vin), .kin(kin), .din(din),
    .ostall(ostall), .ev(ev1), .ek(ek1), .ed(ed1), .es(es1));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // cycle-by-cycle comparison against the behavioural models
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int o = 0; o < NP; o++) begin
        chk(v0[o] == ev0[o], $sformatf("R1 R4 R5 R7 R8 R9 rr valid out%0d", o), 64'(v0[o]), 64'(ev0[o]));
        if (v0[o] && ev0[o]) begin
          chk(k0[2*o +: 2] == ek0[2*o +: 2], "R1 R4 R5 rr kind", 64'(k0[2*o +: 2]), 64'(ek0[2*o +: 2]));
          chk(d0[DW*o +: DW] == ed0[DW*o +: DW], "R3 R5 rr data", 64'(d0[DW*o +: DW]), 64'(ed0[DW*o +: DW]));
        end
        chk(v1[o] == ev1[o], $sformatf("R1 R4 R6 R7 R8 R9 fixed valid out%0d", o), 64'(v1[o]), 64'(ev1[o]));
        if (v1[o] && ev1[o]) begin
          chk(k1[2*o +: 2] == ek1[2*o +: 2], "R1 R4 R6 fixed kind", 64'(k1[2*o +: 2]), 64'(ek1[2*o +: 2]));
          chk(d1[DW*o +: DW] == ed1[DW*o +: DW], "R3 R6 fixed data", 64'(d1[DW*o +: DW]), 64'(ed1[DW*o +: DW]));
        end
        chk(s0[o] == es0[o], "R2 rr stall", 64'(s0[o]), 64'(es0[o]));
        chk(s1[o] == es1[o], "R2 fixed stall", 64'(s1[o]), 64'(es1[o]));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    int rem [NP];
    logic [NP-1:0] lag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    chk(v0 == '0 && v1 == '0, "R2 reset outputs", 64'({v0, v1}), 64'(0));
    chk(s0 == '0 && s1 == '0, "R2 reset stall", 64'({s0, s1}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // R8, R3: single flit to output 3, route 0xA3 -> next 0x14
    vin[0] = 1'b1; kin[1:0] = 2'd3; din[31:0] = 32'h0000_00A3;
    @(negedge clk);
    vin = '0;
    chk(v0[3] == 1'b0, "R8 not before transfer edge", 64'(v0[3]), 64'(0));
    @(negedge clk);
    chk(v0[3] && v1[3], "R8 flit out after one stage", 64'({v0[3], v1[3]}), 64'(3));
    chk(d0[96 +: 32] == 32'h14 && k0[7:6] == 2'd3, "R3 route shift", 64'(d0[96 +: 32]), 64'h14);
    // R2, R7: fill input 1 under downstream stop
    ostall = '1;
    for (int n = 0; n < 4; n++) begin
      vin[1] = 1'b1;
      kin[3:2] = (n == 0) ? 2'd1 : (n == 3) ? 2'd2 : 2'd0;
      din[63:32] = (n == 0) ? 32'h0000_0010 : 32'hBEEF_0000 + n;
      @(negedge clk);
      if (n == 1) chk(s0[1] == 1'b0, "R2 stall low at two", 64'(s0[1]), 64'(0));
      if (n == 2) chk(s0[1] == 1'b1, "R2 stall high at three", 64'(s0[1]), 64'(1));
      if (n == 2) chk(v0 == '0 && v1 == '0, "R7 no flit while stopped", 64'({v0, v1}), 64'(0));
    end
    vin = '0;
    ostall = '0;
    repeat (10) @(negedge clk);
    // mixed traffic, sender reacts to stop one cycle late
    for (int i = 0; i < NP; i++) rem[i] = 0;
    lag = s0 | s1;
    for (int c = 0; c < 3000; c++) begin
      for (int o = 0; o < NP; o++)
        ostall[o] = (c < 1000) ? ($urandom % 4 == 0) : (c < 2000) ? ($urandom % 4 != 0) : 1'b0;
      for (int i = 0; i < NP; i++) begin
        vin[i] = 1'b0;
        if (!lag[i] && ($urandom % 4 != 0)) begin
          logic [31:0] d;
          d = $urandom;
          vin[i] = 1'b1;
          if (rem[i] == 0) begin
            int len;
            len = 1 + int'($urandom % 4);
            d[2:0] = 3'($urandom % NP);
            kin[2*i +: 2] = (len == 1) ? 2'd3 : 2'd1;
            rem[i] = len - 1;
          end else begin
            rem[i] = rem[i] - 1;
            kin[2*i +: 2] = (rem[i] == 0) ? 2'd2 : 2'd0;
          end
          din[DW*i +: DW] = d;
        end
      end
      lag = s0 | s1;
      @(negedge clk);
    end
    vin = '0;
    ostall = '0;
    repeat (40) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule